// File: doc/BRIEF.md
# Self-Seeding Rotating Pattern Register

This block holds an N-bit pattern that starts from a fixed seed and then turns around its own width forever. A free-running prescaler divides the system clock by 2^K and emits a one-cycle step pulse. The register changes only on that pulse. A one-shot flag, cleared by reset, marks the first pulse as a load: that edge captures the seed and sets the flag. Every later pulse rotates the pattern by one place toward the top. The old top bit is fed straight back into bit 0.

The pattern is meant to drive a row of indicator lights that visibly chase. It needs only a clock and a reset, so there is no data input. The width, the seed and the divider exponent are parameters. The step pulse is brought out so that a neighbour can follow the pattern's cadence.

Top module: `rot_seed_reg`

## Requirements
- R1: While the synchronous active-high reset is sampled high on a rising edge, that edge clears the pattern, the load flag and the prescaler count. In the next cycle, the pattern reads all zeros and step reads 0.
- R2: step is high for exactly one cycle out of every 2^K. Let n be the number of rising edges since the last edge on which reset was high. Then step is high exactly when n mod 2^K equals 2^K-1.
- R3: On edges where step is low, the pattern keeps its value.
- R4: The first step edge after reset loads the SEED parameter into the pattern.
- R5: Every later step edge rotates the pattern left by one place. Bit i moves to bit i+1, and bit WIDTH-1 enters bit 0.
- R6: Once the seed has been loaded, the block never loads again until the next reset. After the m-th step edge (m at least 1), the pattern equals SEED rotated left by (m-1) mod WIDTH places.
- R7: When reset and a step fall on the same edge, reset wins. The pattern is cleared, and the next step edge loads the seed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step | output | 1 | One-cycle pulse on the edges where the pattern advances |
| pattern | output | WIDTH | Current register contents |

## Verification
Reset and the prescaler pulse can fall on the same edge. In that case the pulse's load or rotate competes with the clear. The bench waits until it sees step high and then raises reset for that very edge. It does this both before and after the seed load, and it also adds random resets at other phases. It then judges the result against a model that counts edges since reset: the pattern must read zero afterwards, and the next pulse must load the seed afresh.

// File: rtl/rot_seed_reg.sv
module rot_seed_reg #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] SEED = 4'b0001,
  parameter int DIV_EXP = 22
) (
  input  logic             clk,
  input  logic             rst,
  output logic             step,
  output logic [WIDTH-1:0] pattern
);

  logic [DIV_EXP-1:0] div_cnt;
  logic               loaded;

  assign step = &div_cnt;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded  <= 1'b0;
      pattern <= '0;
    end else if (step) begin
      loaded <= 1'b1;
      if (!loaded) pattern <= SEED;
      else         pattern <= {pattern[WIDTH-2:0], pattern[WIDTH-1]};
    end
  end

endmodule

// File: rtl/rot_seed_reg_chk.sv
module rot_seed_reg_chk #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] SEED = 4'b0001
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             mode,
  input logic [WIDTH-1:0] pattern
);

  p_clear_r1: assert property (@(posedge clk) rst |=> (pattern == '0 && !mode && !step));

  p_pulse_r2: assert property (@(posedge clk) disable iff (rst) step |=> !step);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(pattern));

  p_seed_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !mode) |=> (pattern == SEED && mode));

  p_turn_r5: assert property (@(posedge clk) disable iff (rst)
    (step && mode) |=> (pattern == {$past(pattern[WIDTH-2:0]), $past(pattern[WIDTH-1])}));

  p_lock_r6: assert property (@(posedge clk) disable iff (rst) mode |=> mode);

endmodule

bind rot_seed_reg rot_seed_reg_chk #(.WIDTH(WIDTH), .SEED(SEED)) i_chk (
  .clk(clk), .rst(rst), .step(step), .mode(loaded), .pattern(pattern)
);

// File: tb/test_rot_seed_reg.sv
module test_rot_seed_reg;
  localparam int W = 4;
  localparam int K = 3;
  localparam int P = 1 << K;
  localparam logic [W-1:0] S = 4'b1001;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step;
  logic [W-1:0] pattern;
  int           n = 0;
  int           total = 0;
  int           bad = 0;
  bit           coin_seen = 1'b0;

  always #10 clk = ~clk;

  rot_seed_reg #(.WIDTH(W), .SEED(S), .DIV_EXP(K)) i_rot_seed_reg (
    .clk(clk), .rst(rst), .step(step), .pattern(pattern)
  );

  always @(posedge clk) n <= rst ? 0 : n + 1;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int k);
    logic [W-1:0] r = v;
    for (int i = 0; i < k; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  function automatic logic [W-1:0] exp_pat(input int edges);
    int m = edges / P;
    if (m == 0) return '0;
    return rotl(S, (m - 1) % W);
  endfunction

  task automatic check_now(input string tag);
    logic         es = ((n % P) == P - 1);
    logic [W-1:0] ep = exp_pat(n);
    total++;
    if (step !== es) begin
      bad++;
      $display("FAIL R2 step n=%0d actual=%b expected=%b", n, step, es);
    end
    total++;
    if (pattern !== ep) begin
      bad++;
      $display("FAIL %s pattern n=%0d actual=%b expected=%b", tag, n, pattern, ep);
    end
  endtask

  function automatic string tag_for(input int edges, input bit after_coin);
    int m = edges / P;
    if (after_coin) return "R7";
    if (edges == 0) return "R1";
    if (m == 1 && edges % P == 0) return "R4";
    if (edges % P != 0) return "R3";
    if (m > W) return "R6";
    return "R5";
  endfunction

  initial begin
    bit coin = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_now("R1");
    rst = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      check_now(tag_for(n, coin));
      coin = 1'b0;
      if (step && ((cyc % 500) > 480 || $urandom_range(0, 99) == 0)) begin
        rst = 1'b1;
        coin = 1'b1;
        coin_seen = 1'b1;
      end else if ($urandom_range(0, 399) == 0) begin
        rst = 1'b1;
      end else begin
        rst = 1'b0;
      end
    end
    total++;
    if (!coin_seen) begin
      bad++;
      $display("FAIL R7 coincidence actual=0 expected=1");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule